// File: doc/BRIEF.md
# Infrared Mark/Space Width Recorder

This block watches the demodulated output of an infrared receiver. It samples the line once per programmable sampling period. It measures every mark (line active) and every space (line idle) as an 8-bit count of samples, and writes the counts one after another into a bank of 32-bit words that software can read. A de-glitch filter runs ahead of the measurement, so a level change counts only after it has held for a programmable number of samples.

A message is complete when the line has stayed at the space level long enough for the width counter to saturate, and a further programmable number of samples has then passed. At that point the block appends a saturated space entry, sets a sticky interrupt status and stops recording. Software reads the bank, writes the restart bit to clear the bank and make the engine wait for a new message, and then clears the status. Protocol decoding is left to software.

Top module: `ir_pulse_capture`

## Requirements
- R1: A mark or space that lasts 255 samples or more is stored as 0xFF. Shorter intervals are stored as their exact sample count.
- R2: Capture word i is read at address 0x40 + 4*i. Entry 4*i+j sits in bits 8*j+7 down to 8*j of that word, so the earliest entry is in the lowest byte.
- R3: The bank holds at most 68 entries. Once 68 entries are stored, later intervals are not stored and the stored entries keep their values.
- R4: Recording starts with the first accepted mark. Entry 0 is that mark, and the entries then alternate space, mark, space and so on.
- R5: Writing 1 to bit 0 at address 0x08 clears every capture word to zero and returns the engine to waiting for a first mark.
- R6: No sample is taken unless both bit 0 and bit 13 of the control register (address 0x00) are set. With either bit clear, line activity changes neither the bank nor the status.
- R7: The filter field at bits 12:8 of address 0x04 holds N. A new input level is accepted only after N consecutive samples show it. N = 0 behaves like N = 1.
- R8: The interrupt status (bit 0 at 0x10) stays set until software writes 1 to it. The irq output is high exactly when that status and the enable (bit 0 at 0x0C) are both set.
- R9: With K in bits 23:16 of the control register, completion happens on space sample 256+K after at least one mark. It appends a 0xFF entry when the bank has room and sets the status. Until the next restart, line activity is ignored.
- R10: A line that has shown no mark since the last restart never completes, however long it stays idle.
- R11: With value P in address 0x14, one sample is taken every P+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated receiver line, 1 = mark |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Message-complete interrupt |

## Verification
The bench uses the default parameters: 17 capture words of four 8-bit lanes and an 8-bit period field. Most runs program a period value of 1, so each sample takes two clocks. At that rate the 256-sample idle window, a 300-sample saturated mark and an 80-interval overflow of the 68-entry bank all fit in a short run. One directed message is repeated at period value 3 to show that the stored widths stay in sample units. A filter setting of 0 shows a single-sample glitch being stored, and a setting of 2 shows the same glitch being absorbed into the surrounding mark.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
   localparam int ADR_CTRL    = 'h00;
   localparam int ADR_FILTER  = 'h04;
   localparam int ADR_RESTART = 'h08;
   localparam int ADR_IRQEN   = 'h0C;
   localparam int ADR_STAT    = 'h10;
   localparam int ADR_PERIOD  = 'h14;
   localparam int ADR_BANK    = 'h40;

   localparam int BIT_RUN     = 0;
   localparam int BIT_DETECT  = 13;
   localparam int LSB_OKCNT   = 16;
   localparam int LSB_FILTER  = 8;

   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_RUN  = 2'd1,
      CAP_DONE = 2'd2
   } cap_state_e;
endpackage

// File: rtl/ir_cap_ticker.sv
module ir_cap_ticker #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [PERIOD_W-1:0] per,
   output logic                tick
);
   logic [PERIOD_W-1:0] cnt_q;

   assign tick = run && (cnt_q >= per);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/ir_cap_deglitch.sv
module ir_cap_deglitch #(
   parameter int DG_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ir_in,
   input  logic            tick,
   input  logic [DG_W-1:0] dg_n,
   output logic            lvl
);
   logic [1:0]      sync_q;
   logic [DG_W-1:0] cnt_q;
   logic [DG_W:0]   need;
   logic [DG_W:0]   seen;

   assign need = (dg_n == '0) ? (DG_W+1)'(1) : {1'b0, dg_n};
   assign seen = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         cnt_q  <= '0;
         lvl    <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], ir_in};
         if (tick) begin
            if (sync_q[1] == lvl) begin
               cnt_q <= '0;
            end else if (seen >= need) begin
               lvl   <= sync_q[1];
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ir_cap_core.sv
module ir_cap_core
   import ir_cap_pkg::*;
#(
   parameter int ENTRIES = 68,
   parameter int WID_W   = 8,
   parameter int OK_W    = 8,
   parameter int IDX_W   = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     lvl,
   input  logic                     restart,
   input  logic [OK_W-1:0]          ok_lim,
   output logic [ENTRIES*WID_W-1:0] bank,
   output logic [IDX_W-1:0]         entry_cnt,
   output logic                     done,
   output logic                     done_pulse
);
   localparam logic [WID_W-1:0] W_SAT = '1;

   cap_state_e              st_q;
   logic                    cur_q;
   logic [WID_W-1:0]        w_q;
   logic [OK_W-1:0]         okc_q;
   logic [IDX_W-1:0]        idx_q;
   logic [ENTRIES*WID_W-1:0] bank_q;
   logic                    full;
   logic                    fire;

   assign full       = (idx_q == IDX_W'(ENTRIES));
   assign fire       = tick && (st_q == CAP_RUN) && (lvl == cur_q) && !cur_q &&
                       (w_q == W_SAT) && (okc_q == ok_lim);
   assign bank       = bank_q;
   assign entry_cnt  = idx_q;
   assign done       = (st_q == CAP_DONE);
   assign done_pulse = fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CAP_IDLE;
         cur_q  <= 1'b0;
         w_q    <= '0;
         okc_q  <= '0;
         idx_q  <= '0;
         bank_q <= '0;
      end else if (restart) begin
         st_q   <= CAP_IDLE;
         cur_q  <= 1'b0;
         w_q    <= '0;
         okc_q  <= '0;
         idx_q  <= '0;
         bank_q <= '0;
      end else if (tick) begin
         case (st_q)
            CAP_IDLE: begin
               if (lvl) begin
                  st_q  <= CAP_RUN;
                  cur_q <= 1'b1;
                  w_q   <= WID_W'(1);
                  okc_q <= '0;
               end
            end
            CAP_RUN: begin
               if (lvl != cur_q) begin
                  if (!full) begin
                     bank_q[idx_q*WID_W +: WID_W] <= w_q;
                     idx_q <= idx_q + 1'b1;
                  end
                  cur_q <= lvl;
                  w_q   <= WID_W'(1);
                  okc_q <= '0;
               end else if (w_q != W_SAT) begin
                  w_q <= w_q + 1'b1;
               end else if (!cur_q) begin
                  if (okc_q == ok_lim) begin
                     if (!full) begin
                        bank_q[idx_q*WID_W +: WID_W] <= W_SAT;
                        idx_q <= idx_q + 1'b1;
                     end
                     st_q <= CAP_DONE;
                  end else begin
                     okc_q <= okc_q + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
   import ir_cap_pkg::*;
#(
   parameter int NUM_WORDS = 17,
   parameter int DATA_W    = 32,
   parameter int WID_W     = 8,
   parameter int PERIOD_W  = 8,
   parameter int DG_W      = 5,
   parameter int OK_W      = 8,
   parameter int ADDR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_in,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int LANES   = DATA_W / WID_W;
   localparam int ENTRIES = NUM_WORDS * LANES;
   localparam int IDX_W   = $clog2(ENTRIES + 1);

   generate
      if (DATA_W % WID_W != 0) begin : g_bad_lane
         $error("DATA_W must be a whole number of width lanes");
      end
      if (DATA_W < LSB_OKCNT + OK_W || DATA_W <= BIT_DETECT) begin : g_bad_ctrl
         $error("control fields do not fit in DATA_W");
      end
      if (DATA_W < PERIOD_W || DATA_W < LSB_FILTER + DG_W) begin : g_bad_timing
         $error("timing fields do not fit in DATA_W");
      end
      if (ADR_BANK + 4*NUM_WORDS > (1 << ADDR_W)) begin : g_bad_addr
         $error("capture bank exceeds the address space");
      end
   endgenerate

   logic                     en_q, det_q, irqen_q, stat_q;
   logic [OK_W-1:0]          okc_cfg_q;
   logic [DG_W-1:0]          dg_q;
   logic [PERIOD_W-1:0]      per_q;
   logic                     run_en, tick, lvl, restart, stat_clr;
   logic [ENTRIES*WID_W-1:0] bank;
   logic [IDX_W-1:0]         entry_cnt;
   logic                     done_st, done_pulse;

   assign run_en   = en_q && det_q;
   assign restart  = reg_we && (reg_addr == ADDR_W'(ADR_RESTART)) && reg_wdata[0];
   assign stat_clr = reg_we && (reg_addr == ADDR_W'(ADR_STAT)) && reg_wdata[0];
   assign irq      = stat_q && irqen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         det_q     <= 1'b0;
         okc_cfg_q <= '0;
         dg_q      <= '0;
         per_q     <= '0;
         irqen_q   <= 1'b0;
         stat_q    <= 1'b0;
      end else begin
         if (reg_we && reg_addr == ADDR_W'(ADR_CTRL)) begin
            en_q      <= reg_wdata[BIT_RUN];
            det_q     <= reg_wdata[BIT_DETECT];
            okc_cfg_q <= reg_wdata[LSB_OKCNT +: OK_W];
         end
         if (reg_we && reg_addr == ADDR_W'(ADR_FILTER)) dg_q    <= reg_wdata[LSB_FILTER +: DG_W];
         if (reg_we && reg_addr == ADDR_W'(ADR_PERIOD)) per_q   <= reg_wdata[PERIOD_W-1:0];
         if (reg_we && reg_addr == ADDR_W'(ADR_IRQEN))  irqen_q <= reg_wdata[0];
         if (done_pulse)    stat_q <= 1'b1;
         else if (stat_clr) stat_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADR_CTRL)) begin
         reg_rdata[BIT_RUN]             = en_q;
         reg_rdata[BIT_DETECT]          = det_q;
         reg_rdata[LSB_OKCNT +: OK_W]   = okc_cfg_q;
      end
      if (reg_addr == ADDR_W'(ADR_FILTER)) reg_rdata[LSB_FILTER +: DG_W] = dg_q;
      if (reg_addr == ADDR_W'(ADR_PERIOD)) reg_rdata[PERIOD_W-1:0]       = per_q;
      if (reg_addr == ADDR_W'(ADR_IRQEN))  reg_rdata[0]                  = irqen_q;
      if (reg_addr == ADDR_W'(ADR_STAT))   reg_rdata[0]                  = stat_q;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (reg_addr == ADDR_W'(ADR_BANK + 4*i)) reg_rdata = bank[i*DATA_W +: DATA_W];
      end
   end

   ir_cap_ticker #(.PERIOD_W(PERIOD_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run_en), .per(per_q), .tick(tick)
   );

   ir_cap_deglitch #(.DG_W(DG_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .tick(tick), .dg_n(dg_q), .lvl(lvl)
   );

   ir_cap_core #(.ENTRIES(ENTRIES), .WID_W(WID_W), .OK_W(OK_W), .IDX_W(IDX_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(lvl), .restart(restart),
      .ok_lim(okc_cfg_q), .bank(bank), .entry_cnt(entry_cnt),
      .done(done_st), .done_pulse(done_pulse)
   );
endmodule

// File: rtl/ir_cap_checker.sv
module ir_cap_checker
   import ir_cap_pkg::*;
#(
   parameter int ENTRIES = 68,
   parameter int IDX_W   = 7,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              stat,
   input logic [IDX_W-1:0]  entry_cnt,
   input logic              done,
   input logic              tick,
   input logic              run
);
   logic wr_restart, wr_clear;
   assign wr_restart = reg_we && (reg_addr == ADDR_W'(ADR_RESTART)) && reg_wdata[0];
   assign wr_clear   = reg_we && (reg_addr == ADDR_W'(ADR_STAT)) && reg_wdata[0];

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      entry_cnt <= IDX_W'(ENTRIES));

   assert_restart_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_restart |=> (entry_cnt == '0));

   assert_gate_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

   assert_sticky_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && !wr_clear) |=> stat);

   assert_frozen_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr_restart) |=> $stable(entry_cnt));

   assert_mark_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (entry_cnt >= IDX_W'(2)));
endmodule

bind ir_pulse_capture ir_cap_checker #(
   .ENTRIES(ENTRIES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .stat(stat_q), .entry_cnt(entry_cnt),
   .done(done_st), .tick(tick), .run(run_en)
);

// File: tb/sim_ir_pulse_capture.sv
`timescale 1ns/1ps
module sim_ir_pulse_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ir_in = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   int per    = 1;
   int wv [80];
   int exb [68];

   always #2.5 clk = ~clk;

   ir_pulse_capture u0 (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 8'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic samples(input int n);
      repeat (n * (per + 1)) @(negedge clk);
   endtask

   task automatic send(input int n);
      for (int k = 0; k < n; k++) begin
         ir_in = (k % 2 == 0);
         samples(wv[k]);
      end
      ir_in = 1'b0;
   endtask

   function automatic void expect_msg(input int n, input bit tail);
      for (int k = 0; k < 68; k++) exb[k] = 0;
      for (int k = 0; k < n && k < 68; k++) exb[k] = (wv[k] > 255) ? 255 : wv[k];
      if (tail && n < 68) exb[n] = 255;
   endfunction

   function automatic logic [31:0] exp_word(input int i);
      return {8'(exb[4*i+3]), 8'(exb[4*i+2]), 8'(exb[4*i+1]), 8'(exb[4*i])};
   endfunction

   task automatic check_bank(input string req);
      logic [31:0] d;
      for (int i = 0; i < 17; i++) begin
         rd('h40 + 4*i, d);
         chk(d == exp_word(i), req, d, exp_word(i));
      end
   endtask

   task automatic ctrl(input int k, input bit det);
      wr('h00, (32'(k) << 16) | (32'(det) << 13) | 32'd1);
   endtask

   task automatic clear_all();
      wr('h08, 32'd1);
      wr('h10, 32'd1);
   endtask

   task automatic wait_done(input int k, input string req);
      samples(246 + k);
      chk(irq == 1'b0, {req, " early"}, 32'(irq), 32'd0);
      samples(30);
      chk(irq == 1'b1, {req, " fired"}, 32'(irq), 32'd1);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int n, k;
      void'($urandom(32'd20250611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd('h00, d); chk(d == 0, "R6 reset ctrl", d, 0);
      rd('h10, d); chk(d == 0, "R8 reset status", d, 0);
      chk(irq == 1'b0, "R8 reset irq", 32'(irq), 0);
      for (int i = 0; i < 68; i++) exb[i] = 0;
      check_bank("R5 reset bank");

      wr('h14, 32'd1);
      wr('h04, 32'd2 << 8);
      wr('h0C, 32'd1);
      ctrl(3, 1'b1);

      // directed message with a saturated mark: R1 R2 R4 R9
      wv[0] = 10; wv[1] = 20; wv[2] = 300; wv[3] = 5; wv[4] = 7;
      send(5);
      wait_done(3, "R9 directed");
      expect_msg(5, 1'b1);
      check_bank("R1 R2 R4 directed");
      rd('h10, d); chk(d == 1, "R8 status set", d, 1);

      // activity after completion is ignored: R9
      wv[0] = 10; wv[1] = 10; wv[2] = 10;
      send(3);
      samples(20);
      wv[0] = 10; wv[1] = 20; wv[2] = 300; wv[3] = 5; wv[4] = 7;
      check_bank("R9 ignored after done");

      // restart clears the bank, status stays: R5 R8
      wr('h08, 32'd1);
      for (int i = 0; i < 68; i++) exb[i] = 0;
      check_bank("R5 restart");
      rd('h10, d); chk(d == 1, "R8 status sticky", d, 1);
      wr('h10, 32'd1);
      rd('h10, d); chk(d == 0, "R8 status cleared", d, 0);
      chk(irq == 1'b0, "R8 irq cleared", 32'(irq), 0);

      // masked interrupt: R8
      wr('h0C, 32'd0);
      ctrl(0, 1'b1);
      wv[0] = 8; wv[1] = 8; wv[2] = 8;
      send(3);
      samples(300);
      chk(irq == 1'b0, "R8 masked irq", 32'(irq), 0);
      rd('h10, d); chk(d == 1, "R8 masked status", d, 1);
      wr('h0C, 32'd1);
      #1;
      chk(irq == 1'b1, "R8 unmasked irq", 32'(irq), 1);
      clear_all();

      // idle line never completes: R10
      samples(600);
      rd('h10, d); chk(d == 0, "R10 idle status", d, 0);
      rd('h40, d); chk(d == 0, "R10 idle bank", d, 0);

      // detection bit clear: R6
      ctrl(0, 1'b0);
      wv[0] = 10; wv[1] = 10; wv[2] = 10;
      send(3);
      samples(600);
      rd('h10, d); chk(d == 0, "R6 disabled status", d, 0);
      rd('h40, d); chk(d == 0, "R6 disabled bank", d, 0);
      ctrl(0, 1'b1);
      samples(10);

      // glitch filter: R7
      wv[0] = 4; wv[1] = 1; wv[2] = 4;
      send(3);
      wait_done(0, "R7 filter 2 done");
      wv[0] = 9;
      expect_msg(1, 1'b1);
      check_bank("R7 glitch absorbed");
      clear_all();
      wr('h04, 32'd0);
      wv[0] = 4; wv[1] = 1; wv[2] = 4;
      send(3);
      wait_done(0, "R7 filter 0 done");
      expect_msg(3, 1'b1);
      check_bank("R7 glitch kept");
      clear_all();
      wr('h04, 32'd2 << 8);

      // slower sampling: R11
      per = 3;
      wr('h14, 32'd3);
      wv[0] = 6; wv[1] = 9; wv[2] = 12;
      send(3);
      wait_done(0, "R11 period done");
      expect_msg(3, 1'b1);
      check_bank("R11 period 3");
      clear_all();
      per = 1;
      wr('h14, 32'd1);

      // bank overflow: R3
      for (int i = 0; i < 80; i++) wv[i] = 5;
      send(80);
      wait_done(0, "R3 full done");
      expect_msg(80, 1'b0);
      check_bank("R3 full bank");
      clear_all();

      // random messages
      for (int t = 0; t < 6; t++) begin
         n = 2 * int'($urandom_range(10, 0)) + 1;
         k = int'($urandom_range(15, 0));
         ctrl(k, 1'b1);
         for (int i = 0; i < n; i++) wv[i] = int'($urandom_range(120, 3));
         send(n);
         wait_done(k, "R9 random");
         expect_msg(n, 1'b1);
         check_bank("R2 R4 random");
         clear_all();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule